// File: doc/BRIEF.md
# Smart-LED Chain Serial Driver

This block drives a chain of addressable RGB LEDs over one data wire. It steps an LED index through the frame, from 0 up to the last LED. For each index it reads a 24-bit colour from an external pixel store through a read port with a latency of one cycle. It places the three colour bytes in a channel order set by a parameter and sends the 24 bits on the line, one pulse per bit, with the pulse width carrying the bit value. When the last LED has been sent, the line stays low for a latch interval so that the chain takes the new colours. The next frame then begins at once.

Every pulse width is a parameter in nanoseconds. The block turns each one into a count of clock cycles, using a parameter that gives the clock period in picoseconds. The defaults suit an 80 MHz clock, a chain of 256 LEDs and green-red-blue byte order.

The control is a four-state machine:
- `ST_FETCH`: waits two cycles after reset so that the first colour can arrive.
- `ST_HIGH`: holds the line high for the pulse of the current bit.
- `ST_LOW`: holds the line low for the gap of the current bit.
- `ST_LATCH`: holds the line low for the latch interval.

The transitions are:
- fetch done: `ST_FETCH` to `ST_HIGH`, loading pixel 0.
- pulse done: `ST_HIGH` to `ST_LOW`.
- next bit: `ST_LOW` to `ST_HIGH`, shifting by one bit.
- next pixel: `ST_LOW` to `ST_HIGH`, loading the next pixel.
- frame end: `ST_LOW` to `ST_LATCH`.
- restart: `ST_LATCH` to `ST_HIGH`, loading pixel 0.

Top module: `led_chain_driver`

## Requirements
- R1: While `rst_n` is low, `dout_o` is 0 and `led_addr_o` is 0.
- R2: Every pulse width is a count of clock cycles, computed as round(width_ns * 1000 / CLK_PS) and never less than 1. With a 5000 ps clock, widths of 20, 40, 35, 25 and 100 ns become 4, 8, 7, 5 and 20 cycles.
- R3: A 0 bit drives the line high for T0H cycles and then low for T0L cycles.
- R4: A 1 bit drives the line high for T1H cycles and then low for T1L cycles.
- R5: Each pixel is sent as 24 bits: the first byte of the selected channel order, then the second, then the third, each byte MSB first. In the default order (green, red, blue), green goes first.
- R6: The `ORDER` parameter selects one of six byte orders: RGB, RBG, GRB, GBR, BRG or BGR. In BGR order, blue goes first and red goes last.
- R7: After reset is released, the line stays low for two cycles. At the second clock edge pixel 0 is loaded. Each load of pixel i sets `led_addr_o` to (i+1) mod NUM_LEDS, and the address changes at no other time.
- R8: After the low phase of the last bit of LED NUM_LEDS-1, the line stays low for TRES cycles, with `led_addr_o` at 0.
- R9: In the cycle after the latch interval ends, the line goes high for the first bit of pixel 0. This pixel is read from the store again, so any change made to the store before that point appears in the new frame.
- R10: If reset is asserted in the middle of a frame, the frame stops at once. After release, the driver restarts from pixel 0 as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| red_i | input | 8 | Red byte from the store, one cycle after the address |
| green_i | input | 8 | Green byte from the store, one cycle after the address |
| blue_i | input | 8 | Blue byte from the store, one cycle after the address |
| led_addr_o | output | clog2(NUM_LEDS), min 1 | Index of the pixel to read next |
| dout_o | output | 1 | Serial line to the first LED in the chain |

## Verification
The assertions assume three things about the inputs. The colour bytes reflect the address seen at the previous clock edge. Every pulse parameter converts to at least one cycle. `NUM_LEDS` is at least 1, so the address never passes the last index.

The bench's pixel store is a plain registered read of its own array, so the one-cycle latency holds by design. The bench rewrites the store only during a latch interval. At that point the next pixel due to be loaded is pixel 0, and its fetch still has more than two cycles to complete. Two instances share the same timing but use different byte orders. Because each pixel sends the same set of bit values in either order, both instances run frames of equal length.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

    localparam int PIXEL_BITS = 24;

    typedef enum logic [2:0] {
        ORD_RGB,
        ORD_RBG,
        ORD_GRB,
        ORD_GBR,
        ORD_BRG,
        ORD_BGR
    } chan_order_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_HIGH,
        ST_LOW,
        ST_LATCH
    } drv_state_e;

    // Rounded conversion of a width in ns to clock cycles, at least one cycle.
    function automatic int ns_to_cycles(input int width_ns, input int clk_ps);
        int c;
        c = (width_ns * 1000 + clk_ps / 2) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Places the three channel bytes in transmit order, first byte in [23:16].
    function automatic logic [PIXEL_BITS-1:0] arrange(
        input chan_order_e ord,
        input logic [7:0]  r,
        input logic [7:0]  g,
        input logic [7:0]  b
    );
        logic [PIXEL_BITS-1:0] w;
        unique case (ord)
            ORD_RGB: w = {r, g, b};
            ORD_RBG: w = {r, b, g};
            ORD_GRB: w = {g, r, b};
            ORD_GBR: w = {g, b, r};
            ORD_BRG: w = {b, r, g};
            ORD_BGR: w = {b, g, r};
            default: w = {g, r, b};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/led_phase_timer.sv
module led_phase_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expire_o = (cnt_q == limit_i - CW'(1));

    // R3 R4 R8: a phase never runs past the width chosen for it
    cnt_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit_i);

endmodule

// File: rtl/led_frame_addr.sv
module led_frame_addr #(
    parameter int NUM_LEDS = 256,
    parameter int AW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance_i,
    output logic [AW-1:0] addr_o,
    output logic          at_start_o
);

    localparam logic [AW-1:0] LAST_IDX = AW'(NUM_LEDS - 1);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (advance_i) begin
            addr_q <= (addr_q == LAST_IDX) ? '0 : addr_q + AW'(1);
        end
    end

    assign addr_o     = addr_q;
    // After the load of the last pixel the index has wrapped to 0.
    assign at_start_o = (addr_q == '0);

    // R7
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= LAST_IDX);

endmodule

// File: rtl/led_pixel_shifter.sv
module led_pixel_shifter
    import led_drv_pkg::*;
#(
    parameter chan_order_e ORDER = ORD_GRB
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       shift_i,
    input  logic [7:0] red_i,
    input  logic [7:0] green_i,
    input  logic [7:0] blue_i,
    output logic       bit_o,
    output logic       last_o
);

    localparam int IW = $clog2(PIXEL_BITS);

    logic [PIXEL_BITS-1:0] shreg_q;
    logic [IW-1:0]         idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
        end else if (load_i) begin
            shreg_q <= arrange(ORDER, red_i, green_i, blue_i);
            idx_q   <= '0;
        end else if (shift_i) begin
            shreg_q <= {shreg_q[PIXEL_BITS-2:0], 1'b0};
            idx_q   <= idx_q + IW'(1);
        end
    end

    assign bit_o  = shreg_q[PIXEL_BITS-1];
    assign last_o = (idx_q == IW'(PIXEL_BITS - 1));

    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < IW'(PIXEL_BITS));

    // R5
    no_shift_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> !last_o);

endmodule

// File: rtl/led_chain_driver.sv
module led_chain_driver
    import led_drv_pkg::*;
#(
    parameter int          NUM_LEDS = 256,
    parameter int          CLK_PS   = 12500,
    parameter int          T0H_NS   = 350,
    parameter int          T0L_NS   = 800,
    parameter int          T1H_NS   = 700,
    parameter int          T1L_NS   = 600,
    parameter int          TRES_NS  = 80000,
    parameter chan_order_e ORDER    = ORD_GRB,
    localparam int         AW       = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    red_i,
    input  logic [7:0]    green_i,
    input  logic [7:0]    blue_i,
    output logic [AW-1:0] led_addr_o,
    output logic          dout_o
);

    localparam int C0H   = ns_to_cycles(T0H_NS, CLK_PS);
    localparam int C0L   = ns_to_cycles(T0L_NS, CLK_PS);
    localparam int C1H   = ns_to_cycles(T1H_NS, CLK_PS);
    localparam int C1L   = ns_to_cycles(T1L_NS, CLK_PS);
    localparam int CRES  = ns_to_cycles(TRES_NS, CLK_PS);
    localparam int CFET  = 2;
    localparam int CMAX  = imax(imax(imax(C0H, C0L), imax(C1H, C1L)), imax(CRES, CFET));
    localparam int TW    = $clog2(CMAX + 1);

    drv_state_e    state_q, state_d;
    logic          load, shift, clear;
    logic          expire, cur_bit, last_bit, frame_end;
    logic [TW-1:0] limit;

    led_phase_timer #(.CW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .limit_i  (limit),
        .expire_o (expire)
    );

    led_frame_addr #(.NUM_LEDS(NUM_LEDS), .AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance_i  (load),
        .addr_o     (led_addr_o),
        .at_start_o (frame_end)
    );

    led_pixel_shifter #(.ORDER(ORDER)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .red_i   (red_i),
        .green_i (green_i),
        .blue_i  (blue_i),
        .bit_o   (cur_bit),
        .last_o  (last_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and datapath strobes
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        shift   = 1'b0;
        clear   = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                if (expire) begin
                    load    = 1'b1;
                    clear   = 1'b1;
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    clear   = 1'b1;
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (expire) begin
                    clear = 1'b1;
                    if (!last_bit) begin
                        shift   = 1'b1;
                        state_d = ST_HIGH;
                    end else if (frame_end) begin
                        state_d = ST_LATCH;
                    end else begin
                        load    = 1'b1;
                        state_d = ST_HIGH;
                    end
                end
            end
            ST_LATCH: begin
                if (expire) begin
                    load    = 1'b1;
                    clear   = 1'b1;
                    state_d = ST_HIGH;
                end
            end
            default: begin
                clear   = 1'b1;
                state_d = ST_FETCH;
            end
        endcase
    end

    // Outputs: line level and the width of the running phase
    always_comb begin
        dout_o = 1'b0;
        limit  = TW'(CFET);
        unique case (state_q)
            ST_FETCH: limit = TW'(CFET);
            ST_HIGH: begin
                dout_o = 1'b1;
                limit  = cur_bit ? TW'(C1H) : TW'(C0H);
            end
            ST_LOW:   limit = cur_bit ? TW'(C1L) : TW'(C0L);
            ST_LATCH: limit = TW'(CRES);
            default:  limit = TW'(CFET);
        endcase
    end

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (led_addr_o == (($past(led_addr_o) == AW'(NUM_LEDS - 1)) ? '0
                                  : $past(led_addr_o) + AW'(1))));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(led_addr_o));

    // R5
    load_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == ST_FETCH || state_q == ST_LATCH || last_bit));

    // R8
    latch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_LATCH) |-> (led_addr_o == '0 && !dout_o));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q == ST_LATCH) |-> (dout_o && led_addr_o == AW'((NUM_LEDS > 1) ? 1 : 0)));

endmodule

// File: tb/led_chain_driver_test.sv
`timescale 1ns/1ps
module led_chain_driver_test;
    import led_drv_pkg::*;

    // R2: 5 ns clock gives 4, 8, 7, 5 and 20 cycles for the widths below
    localparam int N    = 3;
    localparam int E0H  = 4;
    localparam int E0L  = 8;
    localparam int E1H  = 7;
    localparam int E1L  = 5;
    localparam int ERES = 20;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [23:0] pix [N];
    logic [23:0] rd_a, rd_b;
    logic [1:0]  addr_a, addr_b;
    logic        dout_a, dout_b;

    int    total = 0;
    int    bad   = 0;
    bit    cmp_en = 1'b0;
    bit    finished = 1'b0;
    int    q_a[$];
    int    q_b[$];
    string t_a[$];
    string t_b[$];

    // Pixel store with one-cycle read latency, {r,g,b}
    always_ff @(posedge clk) begin
        rd_a <= (addr_a < 2'(N)) ? pix[addr_a] : 24'h0;
        rd_b <= (addr_b < 2'(N)) ? pix[addr_b] : 24'h0;
    end

    led_chain_driver #(
        .NUM_LEDS(N), .CLK_PS(5000), .T0H_NS(20), .T0L_NS(40),
        .T1H_NS(35), .T1L_NS(25), .TRES_NS(100)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .red_i(rd_a[23:16]), .green_i(rd_a[15:8]), .blue_i(rd_a[7:0]),
        .led_addr_o(addr_a), .dout_o(dout_a)
    );

    led_chain_driver #(
        .NUM_LEDS(N), .CLK_PS(5000), .T0H_NS(20), .T0L_NS(40),
        .T1H_NS(35), .T1L_NS(25), .TRES_NS(100), .ORDER(ORD_BGR)
    ) uut_alt (
        .clk(clk), .rst_n(rst_n),
        .red_i(rd_b[23:16]), .green_i(rd_b[15:8]), .blue_i(rd_b[7:0]),
        .led_addr_o(addr_b), .dout_o(dout_b)
    );

    function automatic logic [23:0] seq_grb(input logic [23:0] rgb);
        return {rgb[15:8], rgb[23:16], rgb[7:0]};
    endfunction

    function automatic logic [23:0] seq_bgr(input logic [23:0] rgb);
        return {rgb[7:0], rgb[15:8], rgb[23:16]};
    endfunction

    task automatic push(input bit alt, input int lvl, input int adr, input string tag);
        if (alt) begin
            q_b.push_back(lvl + 2 * adr);
            t_b.push_back(tag);
        end else begin
            q_a.push_back(lvl + 2 * adr);
            t_a.push_back(tag);
        end
    endtask

    // Reference stream of one frame, one entry per clock
    task automatic push_frame(input bit alt);
        for (int i = 0; i < N; i++) begin
            logic [23:0] w;
            w = alt ? seq_bgr(pix[i]) : seq_grb(pix[i]);
            for (int b = 23; b >= 0; b--) begin
                int    th;
                int    tl;
                string tg;
                th = w[b] ? E1H : E0H;
                tl = w[b] ? E1L : E0L;
                if (i == 0 && b == 23) tg = "R9";
                else if (alt)          tg = "R6";
                else                   tg = w[b] ? "R2/R4/R5" : "R2/R3/R5";
                for (int k = 0; k < th; k++) push(alt, 1, (i + 1) % N, tg);
                for (int k = 0; k < tl; k++) push(alt, 0, (i + 1) % N, tg);
            end
        end
        for (int k = 0; k < ERES; k++) push(alt, 0, 0, "R8");
    endtask

    // R7: two low cycles at address 0 follow reset release
    task automatic push_start();
        for (int a = 0; a < 2; a++) begin
            push(a[0], 0, 0, "R7");
            push(a[0], 0, 0, "R7");
        end
    endtask

    task automatic check(input logic d, input logic [1:0] a, input int e,
                         input string tg, input string who);
        total++;
        if (d !== e[0] || a !== 2'(e >> 1)) begin
            bad++;
            $display("FAIL %s %s: dout=%0b addr=%0d expected dout=%0b addr=%0d",
                     tg, who, d, a, e[0], e >> 1);
        end
    endtask

    task automatic check_idle(input string tg);
        @(negedge clk);
        check(dout_a, addr_a, 0, tg, "uut");
        check(dout_b, addr_b, 0, tg, "uut_alt");
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            if (q_a.size() > 0) begin
                int    e;
                string tg;
                e  = q_a.pop_front();
                tg = t_a.pop_front();
                check(dout_a, addr_a, e, tg, "uut");
            end
            if (q_b.size() > 0) begin
                int    e;
                string tg;
                e  = q_b.pop_front();
                tg = t_b.pop_front();
                check(dout_b, addr_b, e, tg, "uut_alt");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pix[0] = 24'hA53C01;
        pix[1] = 24'h00FF80;
        pix[2] = 24'h7E81FF;

        // R1: outputs idle under reset
        for (int k = 0; k < 4; k++) check_idle("R1");

        push_start();
        push_frame(1'b0);
        push_frame(1'b1);
        @(posedge clk); #1;
        rst_n  = 1'b1;
        cmp_en = 1'b1;

        // R9: rewrite the store during the latch of frame 1
        while (q_a.size() > 10) @(posedge clk);
        #1;
        pix[0] = 24'h123456;
        pix[1] = 24'hFF0000;
        pix[2] = 24'h000001;
        push_frame(1'b0);
        push_frame(1'b1);

        // R10: reset in the middle of frame 2
        while (q_a.size() > 400) @(posedge clk);
        #1;
        rst_n  = 1'b0;
        cmp_en = 1'b0;
        q_a.delete();
        q_b.delete();
        t_a.delete();
        t_b.delete();
        for (int k = 0; k < 3; k++) check_idle("R10/R1");

        push_start();
        push_frame(1'b0);
        push_frame(1'b1);
        @(posedge clk); #1;
        rst_n  = 1'b1;
        cmp_en = 1'b1;

        while (q_a.size() > 0 || q_b.size() > 0) @(posedge clk);
        #1;
        cmp_en   = 1'b0;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule